// File: doc/BRIEF.md
# Stride-7 Corner-Turn Buffer for a 1008-Point Prime-Factor FFT

This block reorders data between the 7-point and the 9-point transform stages of a three-dimensional prime-factor FFT of 1008 points. The upstream stage delivers its 7-point results on two parallel streams. Successive 7-point groups take turns on the streams, and each group stays whole on one stream. The block writes every frame into one half of a double-buffered store, in ascending linear order. Meanwhile it scans the other half with a step of seven positions, which collects the nine samples of each 9-point group together. The collected 9-point groups are sent on two output streams, again taking turns.

Each stream beat is 128 bits wide and holds four 32-bit complex samples, so eight samples move per clock in each direction. Groups are packed back to back on a stream and may cross beat boundaries. Because of the double buffer, a new frame can be written while the previous one is read out, and there is no pause between frames. The output has no backpressure.

Top module: `stride7_corner_turn`

## Requirements
- R1: While rst_n is low, and after it is released, out_valid and out_last stay low until a complete frame has been accepted.
- R2: Input sample packing. Lane l of a beat is in bits [32*l+31:32*l], and lane 0 is the earliest sample. Stream A carries the even-numbered 7-point groups and stream B carries the odd-numbered ones. A frame is 126 beats on each stream, with groups packed contiguously. in_last is high exactly on the 126th accepted beat.
- R3: An input sample at point p (0..6) of 7-point group g (groups numbered in arrival order across both streams) takes linear position 7*g + p in the frame.
- R4: Output point n2 (0..8) of 9-point group h equals the input sample at linear position n1 + 7*n2 + 63*n3, where n1 = h mod 7 and n3 = h div 7.
- R5: Output group h goes out on stream A when h is even and on stream B when h is odd. Each stream carries 56 groups packed contiguously, four samples per beat, with the same lane order as R2.
- R6: Each frame produces exactly 126 output beats on consecutive cycles. out_valid stays high throughout, and out_last is high only on the 126th beat.
- R7: The first output beat of a frame appears three cycles after the cycle in which its final input beat was accepted. For a frame sent without gaps, this is 128 cycles after its first beat.
- R8: Input beats count only in cycles where in_valid is high. Data on the inputs in other cycles has no effect on any output sample.
- R9: A new frame may start in the cycle right after the previous frame's final beat. Frames then come out back to back, each one unchanged by the frame being written behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Both input streams carry a beat this cycle |
| in_a_data | input | 128 | Stream A beat: four samples, even 7-point groups |
| in_b_data | input | 128 | Stream B beat: four samples, odd 7-point groups |
| in_last | input | 1 | Marks the final input beat of a frame |
| out_valid | output | 1 | Both output streams carry a beat this cycle |
| out_a_data | output | 128 | Stream A beat: four samples, even 9-point groups |
| out_a_data | output | 128 | Stream A beat: four samples, even 9-point groups |
| out_b_data | output | 128 | Stream B beat: four samples, odd 9-point groups |
| out_last | output | 1 | Marks the final output beat of a frame |

## Verification
The bench goes after beats where a 7-point or 9-point group crosses a beat boundary. A sequencer that handles the carry wrongly would repeat or skip a sample at the start of a group, or place a sample in the wrong lane. It also covers the step where the group index moves into the next plane of 63 samples, where a bad wrap would read a whole plane out of place. Input gaps carry random data, so a design that writes when in_valid is low would corrupt samples. Back-to-back frames check that bank switching does not let the frame being written overwrite the one still being read, and that no beat is dropped or added at the frame seam. Timing against R7 would catch a missing or extra pipeline stage.

// File: rtl/tpose_pkg.sv
// Shared defaults for the stride-7 corner-turn buffer.
// Assumes a frame of DIM_A*DIM_B*DIM_C samples split evenly over two streams.
package tpose_pkg;
    localparam int unsigned DEF_SAMPLE_W = 32;  // one complex sample (16-bit I and Q)
    localparam int unsigned DEF_LANES    = 4;   // samples per beat per stream
    localparam int unsigned DEF_DIM_A    = 7;   // incoming group length, also the read step
    localparam int unsigned DEF_DIM_B    = 9;   // outgoing group length
    localparam int unsigned DEF_DIM_C    = 16;  // third dimension of the cube
endpackage

// File: rtl/tpose_wr_seq.sv
// Write-side sequencer: counts accepted beats and produces the linear
// store address of every lane of both streams, 7*group + point, where
// stream A holds the even groups and stream B the odd ones.
// Assumes LANES <= P1, so one lane offset wraps the point index at most once.
module tpose_wr_seq #(
    parameter int unsigned P1    = 7,
    parameter int unsigned LANES = 4,
    parameter int unsigned BEATS = 126,
    parameter int unsigned FRAME = 1008,
    parameter int unsigned AW    = 10,
    parameter int unsigned BW    = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_last,
    output logic                        wr_bank,
    output logic [2*LANES-1:0][AW-1:0]  wr_addr,
    output logic                        frame_done
);
    localparam int unsigned PW = $clog2(P1) + 1;

    logic [BW-1:0] beat_q;
    logic [PW-1:0] pt_q;
    logic [AW-1:0] pair_q;
    logic [PW-1:0] pt_sum;

    assign frame_done = in_valid && (beat_q == BW'(BEATS - 1));
    assign pt_sum     = pt_q + PW'(LANES);

    // Advance the lane-0 point/pair position and swap banks at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q  <= '0;
            pt_q    <= '0;
            pair_q  <= '0;
            wr_bank <= 1'b0;
        end else if (in_valid) begin
            if (frame_done) begin
                beat_q  <= '0;
                pt_q    <= '0;
                pair_q  <= '0;
                wr_bank <= ~wr_bank;
            end else begin
                beat_q <= beat_q + BW'(1);
                if (pt_sum >= PW'(P1)) begin
                    pt_q   <= pt_sum - PW'(P1);
                    pair_q <= pair_q + AW'(1);
                end else begin
                    pt_q <= pt_sum;
                end
            end
        end
    end

    for (genvar s = 0; s < 2; s++) begin : g_strm
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [PW-1:0] lpt;
            logic [AW-1:0] lpair;

            // Offset the lane from lane 0, carrying into the next group pair.
            always_comb begin
                lpt   = pt_q + PW'(l);
                lpair = pair_q;
                if (lpt >= PW'(P1)) begin
                    lpt   = lpt - PW'(P1);
                    lpair = lpair + AW'(1);
                end
            end

            assign wr_addr[s*LANES+l] = ({lpair[AW-2:0], 1'b0} + AW'(s)) * AW'(P1) + AW'(lpt);

            AST_WR_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> (wr_addr[s*LANES+l] < AW'(FRAME)))
                else $error("write address outside frame"); // R3
        end
    end

    AST_LAST_ON_FINAL_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (in_last == frame_done))
        else $error("in_last not aligned with beat count"); // R2
endmodule

// File: rtl/tpose_rd_seq.sv
// Read-side sequencer: after a frame is complete it scans the filled bank
// with a step of P1, emitting the store address of every lane of both
// streams for 9-point group h and point n2: (h mod P1) + P1*n2 + P1*P2*(h div P1).
// The group position is tracked incrementally, so no divider is used.
// Assumes LANES <= P2 and P1 > 3.
module tpose_rd_seq #(
    parameter int unsigned P1    = 7,
    parameter int unsigned P2    = 9,
    parameter int unsigned LANES = 4,
    parameter int unsigned BEATS = 126,
    parameter int unsigned FRAME = 1008,
    parameter int unsigned AW    = 10,
    parameter int unsigned BW    = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        start_bank,
    output logic                        busy,
    output logic                        scan_bank,
    output logic [2*LANES-1:0][AW-1:0]  rd_addr,
    output logic                        rd_bank,
    output logic                        rd_valid,
    output logic                        rd_last
);
    localparam int unsigned PW1 = $clog2(P1) + 1;
    localparam int unsigned PW2 = $clog2(P2) + 1;

    logic                        active_q;
    logic                        bank_q;
    logic [BW-1:0]               cnt_q;
    logic [PW2-1:0]              n2_q;
    logic [PW1-1:0]              n1b_q;
    logic [AW-1:0]               n3b_q;
    logic [PW2-1:0]              n2_sum;
    logic [PW1-1:0]              n1b_sum;
    logic                        at_end;
    logic [2*LANES-1:0][AW-1:0]  nxt_addr;

    assign n2_sum    = n2_q + PW2'(LANES);
    assign n1b_sum   = n1b_q + PW1'(2);
    assign at_end    = (cnt_q == BW'(BEATS - 1));
    assign busy      = active_q;
    assign scan_bank = bank_q;

    // Scan state: the beat count and the (n1, n3) base of the even group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            bank_q   <= 1'b0;
            cnt_q    <= '0;
            n2_q     <= '0;
            n1b_q    <= '0;
            n3b_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            bank_q   <= start_bank;
            cnt_q    <= '0;
            n2_q     <= '0;
            n1b_q    <= '0;
            n3b_q    <= '0;
        end else if (active_q) begin
            if (at_end) begin
                active_q <= 1'b0;
            end
            cnt_q <= cnt_q + BW'(1);
            if (n2_sum >= PW2'(P2)) begin
                n2_q <= n2_sum - PW2'(P2);
                if (n1b_sum >= PW1'(P1)) begin
                    n1b_q <= n1b_sum - PW1'(P1);
                    n3b_q <= n3b_q + AW'(1);
                end else begin
                    n1b_q <= n1b_sum;
                end
            end else begin
                n2_q <= n2_sum;
            end
        end
    end

    for (genvar s = 0; s < 2; s++) begin : g_strm
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [PW2-1:0] lm;
            logic [PW1-1:0] ln1;
            logic [AW-1:0]  ln3;

            // Lane position: carry into the next group pair, then into the next plane.
            always_comb begin
                lm  = n2_q + PW2'(l);
                ln1 = n1b_q + PW1'(s);
                ln3 = n3b_q;
                if (lm >= PW2'(P2)) begin
                    lm  = lm - PW2'(P2);
                    ln1 = ln1 + PW1'(2);
                end
                if (ln1 >= PW1'(P1)) begin
                    ln1 = ln1 - PW1'(P1);
                    ln3 = ln3 + AW'(1);
                end
            end

            assign nxt_addr[s*LANES+l] = AW'(ln1) + AW'(P1) * AW'(lm) + AW'(P1 * P2) * ln3;

            AST_RD_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
                rd_valid |-> (rd_addr[s*LANES+l] < AW'(FRAME)))
                else $error("read address outside frame"); // R4
        end
    end

    // Address stage control: valid, frame marker and bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_bank  <= 1'b0;
        end else begin
            rd_valid <= active_q;
            rd_last  <= active_q && at_end;
            rd_bank  <= bank_q;
        end
    end

    // Address stage data: registered scan addresses.
    always_ff @(posedge clk) begin
        rd_addr <= nxt_addr;
    end

    AST_NO_SCAN_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!active_q || at_end))
        else $error("new frame completed while previous scan still running"); // R9
endmodule

// File: rtl/tpose_pp_store.sv
// Double-buffered sample store: two banks of FRAME samples, PORTS
// simultaneous writes into one bank and PORTS registered reads from a bank.
// Assumes the write addresses of one beat are distinct. There is no reset;
// contents are defined only once written.
module tpose_pp_store #(
    parameter int unsigned SAMPLE_W = 32,
    parameter int unsigned PORTS    = 8,
    parameter int unsigned FRAME    = 1008,
    parameter int unsigned AW       = 10
) (
    input  logic                             clk,
    input  logic                             wr_en,
    input  logic                             wr_bank,
    input  logic [PORTS-1:0][AW-1:0]         wr_addr,
    input  logic [PORTS-1:0][SAMPLE_W-1:0]   wr_data,
    input  logic                             rd_en,
    input  logic                             rd_bank,
    input  logic [PORTS-1:0][AW-1:0]         rd_addr,
    output logic [PORTS-1:0][SAMPLE_W-1:0]   rd_data
);
    logic [SAMPLE_W-1:0] mem_q [2][FRAME];

    // Scatter one beat of both streams into the bank being filled.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int p = 0; p < int'(PORTS); p++) begin
                mem_q[wr_bank][wr_addr[p]] <= wr_data[p];
            end
        end
    end

    // Gather one output beat from the bank being drained.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            for (int p = 0; p < int'(PORTS); p++) begin
                rd_data[p] <= mem_q[rd_bank][rd_addr[p]];
            end
        end
    end
endmodule

// File: rtl/stride7_corner_turn.sv
// Stride-7 corner-turn buffer. It takes 7-point groups that alternate
// between two 4-sample streams, stores each frame linearly, and reads it
// back with a step of DIM_A so that DIM_B-point groups come out alternating
// between two streams. Output starts three cycles after the final input
// beat. Assumes DIM_B*DIM_C and DIM_A*DIM_C are even, the frame divides into
// 2*LANES-sample beats, and the output stream is never stalled.
module stride7_corner_turn
    import tpose_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned LANES    = DEF_LANES,
    parameter int unsigned DIM_A    = DEF_DIM_A,
    parameter int unsigned DIM_B    = DEF_DIM_B,
    parameter int unsigned DIM_C    = DEF_DIM_C
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [LANES*SAMPLE_W-1:0] in_a_data,
    input  logic [LANES*SAMPLE_W-1:0] in_b_data,
    input  logic                      in_last,
    output logic                      out_valid,
    output logic [LANES*SAMPLE_W-1:0] out_a_data,
    output logic [LANES*SAMPLE_W-1:0] out_b_data,
    output logic                      out_last
);
    localparam int unsigned FRAME = DIM_A * DIM_B * DIM_C;
    localparam int unsigned PORTS = 2 * LANES;
    localparam int unsigned BEATS = FRAME / PORTS;
    localparam int unsigned AW    = $clog2(FRAME);
    localparam int unsigned BW    = $clog2(BEATS + 1);

    logic                            wr_bank;
    logic                            frame_done;
    logic [PORTS-1:0][AW-1:0]        wr_addr;
    logic [PORTS-1:0][SAMPLE_W-1:0]  wr_data;
    logic                            scan_busy;
    logic                            scan_bank;
    logic [PORTS-1:0][AW-1:0]        rd_addr;
    logic                            rd_bank;
    logic                            rd_valid;
    logic                            rd_last;
    logic [PORTS-1:0][SAMPLE_W-1:0]  rd_data;

    for (genvar l = 0; l < LANES; l++) begin : g_pack
        assign wr_data[l]                      = in_a_data[l*SAMPLE_W +: SAMPLE_W];
        assign wr_data[LANES+l]                = in_b_data[l*SAMPLE_W +: SAMPLE_W];
        assign out_a_data[l*SAMPLE_W +: SAMPLE_W] = rd_data[l];
        assign out_b_data[l*SAMPLE_W +: SAMPLE_W] = rd_data[LANES+l];
    end

    tpose_wr_seq #(
        .P1(DIM_A), .LANES(LANES), .BEATS(BEATS), .FRAME(FRAME), .AW(AW), .BW(BW)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .frame_done (frame_done)
    );

    tpose_rd_seq #(
        .P1(DIM_A), .P2(DIM_B), .LANES(LANES), .BEATS(BEATS), .FRAME(FRAME), .AW(AW), .BW(BW)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (frame_done),
        .start_bank (wr_bank),
        .busy       (scan_busy),
        .scan_bank  (scan_bank),
        .rd_addr    (rd_addr),
        .rd_bank    (rd_bank),
        .rd_valid   (rd_valid),
        .rd_last    (rd_last)
    );

    tpose_pp_store #(
        .SAMPLE_W(SAMPLE_W), .PORTS(PORTS), .FRAME(FRAME), .AW(AW)
    ) u_store (
        .clk     (clk),
        .wr_en   (in_valid),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_valid),
        .rd_bank (rd_bank),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Output control, aligned with the registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= rd_valid;
            out_last  <= rd_last;
        end
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_last))
        else $error("output active right after reset"); // R1

    AST_BANKS_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |-> (scan_bank != wr_bank))
        else $error("scan and fill share one bank"); // R9

    AST_BURST_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid)
        else $error("output burst broken before its last beat"); // R6

    AST_LAST_INSIDE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid)
        else $error("out_last without out_valid"); // R6

    AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(frame_done, 3))
        else $error("output burst not three cycles after frame end"); // R7
endmodule

// File: tb/stride7_corner_turn_tb.sv
// Bench: a behavioural model that schedules every expected output beat by
// cycle number, compared against the ports on every falling edge.
module stride7_corner_turn_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SW    = 32;
    localparam int LN    = 4;
    localparam int DA    = 7;
    localparam int DB    = 9;
    localparam int DC    = 16;
    localparam int FRAME = DA * DB * DC;
    localparam int BEATS = FRAME / (2 * LN);
    localparam int DW    = LN * SW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [DW-1:0] in_a_data;
    logic [DW-1:0] in_b_data;
    logic          in_last;
    logic          out_valid;
    logic [DW-1:0] out_a_data;
    logic [DW-1:0] out_b_data;
    logic          out_last;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stride7_corner_turn u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_a_data  (in_a_data),
        .in_b_data  (in_b_data),
        .in_last    (in_last),
        .out_valid  (out_valid),
        .out_a_data (out_a_data),
        .out_b_data (out_b_data),
        .out_last   (out_last)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [SW-1:0] frame_x [FRAME];
    int            exp_cyc[$];
    logic [DW-1:0] exp_a[$];
    logic [DW-1:0] exp_b[$];
    bit            exp_last[$];

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // R2, R3: linear position of stream s, in-stream sample j.
    function automatic int in_pos(input int s, input int j);
        return (2 * (j / DA) + s) * DA + (j % DA);
    endfunction

    // R4, R5: linear position read for stream s, out-stream sample j.
    function automatic int out_pos(input int s, input int j);
        int h = 2 * (j / DB) + s;
        return (h % DA) + DA * (j % DB) + DA * DB * (h / DA);
    endfunction

    // Expected beats of the current frame; the final beat was accepted at edge e.
    task automatic schedule(input int e);
        for (int k = 0; k < BEATS; k++) begin
            logic [DW-1:0] ea;
            logic [DW-1:0] eb;
            for (int l = 0; l < LN; l++) begin
                ea[l*SW +: SW] = frame_x[out_pos(0, LN * k + l)];
                eb[l*SW +: SW] = frame_x[out_pos(1, LN * k + l)];
            end
            exp_cyc.push_back(e + 2 + k);   // R7
            exp_a.push_back(ea);
            exp_b.push_back(eb);
            exp_last.push_back(k == BEATS - 1);
        end
    endtask

    // R8: gap_pct of cycles carry in_valid low with random data.
    task automatic drive_frame(input int gap_pct);
        int sent = 0;
        for (int i = 0; i < FRAME; i++) frame_x[i] = $urandom;
        while (sent < BEATS) begin
            @(negedge clk);
            if (gap_pct > 0 && int'($urandom_range(99)) < gap_pct) begin
                in_valid  = 1'b0;
                in_last   = 1'b0;
                in_a_data = {$urandom, $urandom, $urandom, $urandom};
                in_b_data = {$urandom, $urandom, $urandom, $urandom};
            end else begin
                in_valid = 1'b1;
                in_last  = (sent == BEATS - 1);
                for (int l = 0; l < LN; l++) begin
                    in_a_data[l*SW +: SW] = frame_x[in_pos(0, LN * sent + l)];
                    in_b_data[l*SW +: SW] = frame_x[in_pos(1, LN * sent + l)];
                end
                if (sent == BEATS - 1) schedule(cyc + 1);
                sent++;
            end
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid  = 1'b0;
        in_last   = 1'b0;
        in_a_data = {$urandom, $urandom, $urandom, $urandom};
        in_b_data = {$urandom, $urandom, $urandom, $urandom};
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Cycle-by-cycle comparison against the schedule.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            if (exp_cyc.size() != 0 && exp_cyc[0] == cyc) begin
                check(out_valid === 1'b1, "R7 out_valid in scheduled cycle", DW'(out_valid), DW'(1));
                check(out_a_data === exp_a[0], "R4 R5 stream A beat", out_a_data, exp_a[0]);
                check(out_b_data === exp_b[0], "R4 R5 stream B beat", out_b_data, exp_b[0]);
                check(out_last === exp_last[0], "R6 out_last", DW'(out_last), DW'(exp_last[0]));
                void'(exp_cyc.pop_front());
                void'(exp_a.pop_front());
                void'(exp_b.pop_front());
                void'(exp_last.pop_front());
            end else begin
                check(out_valid === 1'b0 && out_last === 1'b0, "R1 R6 outputs idle off schedule",
                      DW'({out_valid, out_last}), DW'(0));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            report();
        end
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_last   = 1'b0;
        in_a_data = '0;
        in_b_data = '0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && out_last === 1'b0, "R1 outputs low in reset",
              DW'({out_valid, out_last}), DW'(0));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle(10);
        // R2 R3 R4 R5 R6 R7: one frame without gaps.
        drive_frame(0);
        idle(140);
        // R8: gaps with random data on the idle inputs.
        drive_frame(35);
        idle(140);
        // R9: three frames back to back, the last with gaps.
        drive_frame(0);
        drive_frame(0);
        drive_frame(20);
        idle(140);
        check(exp_cyc.size() == 0, "R6 every scheduled beat emitted", DW'(exp_cyc.size()), DW'(0));
        report();
    end
endmodule